// File: doc/BRIEF.md
# Lockable GPIO Controller with Drive Modes

This block is a memory-mapped GPIO controller for up to 32 pins. Software reaches it over a simple single-cycle register bus: an address, a write strobe, a write word and a combinational read word. Each pin has one bit in every register. The pad inputs are resynchronised and can be read back. The output data bit is changed only through separate write-one-to-set and write-one-to-clear offsets, so one pin can change without a read-modify-write.

Two per-pin mode bits choose the drive style, and the result also depends on the output data bit. A pin can be a high-impedance input, a push-pull output, a pull-low-only output or a pull-high-only output. The mode registers are guarded by a key-protected lock. The lock becomes active only when the magic key is written, and mode writes of any kind take effect only while it is held. Saved mode words can be written back whole while the lock is held. Each pin drives a value and an output enable toward an external pad cell.

Top module: `gpio_lockable`

## Requirements
- R1: After reset, data-out, mode1 and mode0 are all zero and the lock is inactive. Every pad output enable is low and every pad output value is low.
- R2: A write to 0x14 sets the data-out bits where the write word is 1. A write to 0x18 clears the data-out bits where the write word is 1. Bits that are 0 in the word leave their pins unchanged. These writes do not depend on the lock.
- R3: When a pin has {mode1,mode0}=00, its output enable is low for either data-out value.
- R4: When a pin has {mode1,mode0}=01, its output enable is high and its output value equals data-out.
- R5: When a pin has {mode1,mode0}=10, data-out 0 gives output enable high with value 0, and data-out 1 gives output enable low.
- R6: When a pin has {mode1,mode0}=11, data-out 1 gives output enable high with value 1, and data-out 0 gives output enable low. In every mode the output value is 0 whenever the output enable is low.
- R7: A write to the lock offset 0x80 with low 16 bits 0xD42F makes the lock active. A write with low 16 bits 0x0000 releases it. Any other value leaves the lock unchanged. A read of 0x80 returns the lock status in bit 31, with all other bits zero.
- R8: While the lock is inactive, writes to 0x08, 0x0C, 0x50, 0x54 and 0x58 have no effect on the mode registers or on the pads.
- R9: While the lock is active, a write to 0x08 loads mode1 and a write to 0x0C loads mode0 as whole words. A write to 0x54 sets mode0 bits, a write to 0x58 clears mode0 bits, and a write to 0x50 clears mode1 bits, each where the word is 1. Reads of 0x08 and 0x0C return mode1 and mode0.
- R10: A read of 0x04 returns the pad inputs through a two-flop synchroniser. A pad change made between two clock edges appears in the read only after the second following rising edge.
- R11: Reads of the write-only offsets 0x14, 0x18, 0x50, 0x54, 0x58 and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW (8) | Register byte address |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write word |
| rdata_o | output | 32 | Combinational read word for addr_i |
| pad_in_i | input | NPIN (32) | Pad input levels, asynchronous |
| pad_out_o | output | NPIN (32) | Pad output value |
| pad_oe_o | output | NPIN (32) | Pad output enable |

## Verification
Two things can meet in one cycle: a read of the data-in register, and the synchroniser moving a newly changed pad level forward. The bench changes the pad inputs between edges and reads data-in after each following edge. It expects the old value after the first edge and the new one only after the second. The drive decode is swept over all eight combinations of mode pair and data bit on every pin, using rotated bit patterns, and each pad is compared with a value the bench computes arithmetically.

// File: rtl/gpio_lk_pkg.sv
package gpio_lk_pkg;
  localparam int OFS_DIN    = 'h04;
  localparam int OFS_MODE1  = 'h08;
  localparam int OFS_MODE0  = 'h0C;
  localparam int OFS_DSET   = 'h14;
  localparam int OFS_DCLR   = 'h18;
  localparam int OFS_M1CLR  = 'h50;
  localparam int OFS_M0SET  = 'h54;
  localparam int OFS_M0CLR  = 'h58;
  localparam int OFS_LOCK   = 'h80;
  localparam logic [15:0] LOCK_KEY  = 16'hD42F;
  localparam logic [15:0] LOCK_FREE = 16'h0000;
  localparam int LOCK_STAT_BIT = 31;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpio_lock_reg.sv
module gpio_lock_reg
  import gpio_lk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] key_i,
  output logic        active_o
);
  logic act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           act_q <= 1'b0;
    else if (wr_i && key_i == LOCK_KEY)    act_q <= 1'b1;
    else if (wr_i && key_i == LOCK_FREE)   act_q <= 1'b0;
  end

  assign active_o = act_q;

  // R7
  lock_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && key_i == LOCK_KEY) |=> active_o);

  // R7
  lock_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && key_i == LOCK_FREE) |=> !active_o);

  // R7
  lock_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && key_i != LOCK_KEY && key_i != LOCK_FREE) |=> $stable(active_o));
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv #(
  parameter int NPIN = 32
) (
  input  logic [NPIN-1:0] mode1_i,
  input  logic [NPIN-1:0] mode0_i,
  input  logic [NPIN-1:0] dout_i,
  output logic [NPIN-1:0] out_o,
  output logic [NPIN-1:0] oe_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic en, lvl;
    always_comb begin
      unique case ({mode1_i[i], mode0_i[i]})
        2'b00:   en = 1'b0;
        2'b01:   en = 1'b1;
        2'b10:   en = ~dout_i[i];
        default: en = dout_i[i];
      endcase
      // one-sided modes drive a fixed level
      lvl = mode1_i[i] ? mode0_i[i] : dout_i[i];
    end
    assign oe_o[i]  = en;
    assign out_o[i] = en & lvl;
  end
endmodule

// File: rtl/gpio_lockable.sv
module gpio_lockable
  import gpio_lk_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic [NPIN-1:0] pad_in_i,
  output logic [NPIN-1:0] pad_out_o,
  output logic [NPIN-1:0] pad_oe_o
);
  logic [NPIN-1:0] dout_q, mode1_q, mode0_q, din_s, wd;
  logic lock_act;

  assign wd = wdata_i[NPIN-1:0];

  logic wr_dset, wr_dclr, wr_mode1, wr_mode0, wr_m1clr, wr_m0set, wr_m0clr, wr_lock;
  assign wr_dset  = we_i && addr_i == AW'(OFS_DSET);
  assign wr_dclr  = we_i && addr_i == AW'(OFS_DCLR);
  assign wr_mode1 = we_i && addr_i == AW'(OFS_MODE1);
  assign wr_mode0 = we_i && addr_i == AW'(OFS_MODE0);
  assign wr_m1clr = we_i && addr_i == AW'(OFS_M1CLR);
  assign wr_m0set = we_i && addr_i == AW'(OFS_M0SET);
  assign wr_m0clr = we_i && addr_i == AW'(OFS_M0CLR);
  assign wr_lock  = we_i && addr_i == AW'(OFS_LOCK);

  gpio_lock_reg u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_lock),
    .key_i    (wdata_i[15:0]),
    .active_o (lock_act)
  );

  gpio_sync #(.W(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (din_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dout_q <= '0;
    else if (wr_dset) dout_q <= dout_q | wd;
    else if (wr_dclr) dout_q <= dout_q & ~wd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode1_q <= '0;
      mode0_q <= '0;
    end else if (lock_act) begin
      if (wr_mode1) mode1_q <= wd;
      if (wr_m1clr) mode1_q <= mode1_q & ~wd;
      if (wr_mode0) mode0_q <= wd;
      if (wr_m0set) mode0_q <= mode0_q | wd;
      if (wr_m0clr) mode0_q <= mode0_q & ~wd;
    end
  end

  gpio_pad_drv #(.NPIN(NPIN)) u_drv (
    .mode1_i (mode1_q),
    .mode0_i (mode0_q),
    .dout_i  (dout_q),
    .out_o   (pad_out_o),
    .oe_o    (pad_oe_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(OFS_DIN))        rdata_o[NPIN-1:0] = din_s;
    else if (addr_i == AW'(OFS_MODE1)) rdata_o[NPIN-1:0] = mode1_q;
    else if (addr_i == AW'(OFS_MODE0)) rdata_o[NPIN-1:0] = mode0_q;
    else if (addr_i == AW'(OFS_LOCK))  rdata_o[LOCK_STAT_BIT] = lock_act;
  end

  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_act && (wr_mode1 || wr_mode0 || wr_m1clr || wr_m0set || wr_m0clr))
    |=> ($stable(mode1_q) && $stable(mode0_q)));

  // R2
  dset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dset |=> ((dout_q & $past(wd)) == $past(wd)));

  // R2
  dclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dclr |=> ((dout_q & $past(wd)) == '0));

  // R3
  in_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~mode1_q & ~mode0_q) == '0);

  // R6
  out_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);
endmodule

// File: tb/sim_gpio_lockable.sv
`timescale 1ns/1ps
module sim_gpio_lockable;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  gpio_lockable u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] exp_oe(logic [31:0] m1, logic [31:0] m0, logic [31:0] d);
    return (~m1 & m0) | (m1 & ~m0 & ~d) | (m1 & m0 & d);
  endfunction

  function automatic logic [31:0] exp_out(logic [31:0] m1, logic [31:0] m0, logic [31:0] d);
    return exp_oe(m1, m0, d) & ((m1 & m0) | (~m1 & d));
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h08, v); chk("R1 mode1", v, 0);
    rd(8'h0C, v); chk("R1 mode0", v, 0);
    rd(8'h80, v); chk("R1 lock", v, 0);
    chk("R1 oe", pad_oe, 0);
    chk("R1 out", pad_out, 0);

    // R8 writes while unlocked
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0F0F_0F0F);
    wr(8'h54, 32'hFFFF_0000);
    rd(8'h0C, v); chk("R8 mode0 unlocked", v, 0);
    rd(8'h08, v); chk("R8 mode1 unlocked", v, 0);
    chk("R8 oe unlocked", pad_oe, 0);

    // R7 lock key handling
    wr(8'h80, 32'h0000_1234);
    rd(8'h80, v); chk("R7 bad key", v, 0);
    wr(8'h80, 32'hABCD_D42F);
    rd(8'h80, v); chk("R7 take", v, 32'h8000_0000);
    wr(8'h80, 32'h0000_5555);
    rd(8'h80, v); chk("R7 keep", v, 32'h8000_0000);

    // R2 set/clear observed in push-pull mode
    wr(8'h0C, 32'hFFFF_FFFF);
    chk("R3 dout0 push-pull oe", pad_oe, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0000_FFFF);
    chk("R4 R2 set", pad_out, 32'h0000_FFFF);
    wr(8'h18, 32'h0000_00F0);
    chk("R2 clear", pad_out, 32'h0000_FF0F);
    wr(8'h14, 32'h0000_0000);
    chk("R2 zero word set", pad_out, 32'h0000_FF0F);
    wr(8'h18, 32'hFFFF_FFFF);
    chk("R2 clear all", pad_out, 0);

    // R3 R4 R5 R6 sweep of every mode/data pair on every pin
    for (int r = 0; r < 4; r++) begin
      logic [31:0] m1, m0, d;
      m1 = {8{4'b1100}} >> r | {8{4'b1100}} << (32 - r);
      m0 = {8{4'b1010}} >> r | {8{4'b1010}} << (32 - r);
      d  = {4{8'hF0}}  >> r | {4{8'hF0}}  << (32 - r);
      if (r == 0) begin m1 = {8{4'b1100}}; m0 = {8{4'b1010}}; d = {4{8'hF0}}; end
      wr(8'h08, m1);
      wr(8'h0C, m0);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h14, d);
      chk("R3 R4 R5 sweep oe", pad_oe, exp_oe(m1, m0, d));
      chk("R4 R5 R6 sweep out", pad_out, exp_out(m1, m0, d));
    end

    // R9 whole-word load and bit ports
    wr(8'h08, 32'h1234_5678);
    wr(8'h0C, 32'h0000_0000);
    rd(8'h08, v); chk("R9 mode1 load", v, 32'h1234_5678);
    wr(8'h54, 32'h00FF_00FF);
    rd(8'h0C, v); chk("R9 mode0 set", v, 32'h00FF_00FF);
    wr(8'h58, 32'h000F_000F);
    rd(8'h0C, v); chk("R9 mode0 clear", v, 32'h00F0_00F0);
    wr(8'h50, 32'h0000_FFFF);
    rd(8'h08, v); chk("R9 mode1 clear", v, 32'h1234_0000);

    // R7 release, R8 ignored again
    wr(8'h80, 32'hFFFF_0000);
    rd(8'h80, v); chk("R7 release", v, 0);
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk("R8 mode0 after release", v, 32'h00F0_00F0);
    rd(8'h08, v); chk("R8 mode1 after release", v, 32'h1234_0000);

    // R11 unreadable and unmapped offsets
    foreach (v[i]) ; // no-op
    rd(8'h14, v); chk("R11 dset read", v, 0);
    rd(8'h18, v); chk("R11 dclr read", v, 0);
    rd(8'h50, v); chk("R11 m1clr read", v, 0);
    rd(8'h54, v); chk("R11 m0set read", v, 0);
    rd(8'h58, v); chk("R11 m0clr read", v, 0);
    rd(8'h10, v); chk("R11 unmapped 10", v, 0);
    rd(8'hFC, v); chk("R11 unmapped FC", v, 0);

    // R10 synchroniser latency
    @(negedge clk);
    pad_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rd(8'h04, v); chk("R10 settled", v, 32'h1234_5678);
    @(negedge clk);
    pad_in = 32'hCAFE_F00D;
    rd(8'h04, v); chk("R10 no edge", v, 32'h1234_5678);
    @(negedge clk);
    rd(8'h04, v); chk("R10 one edge", v, 32'h1234_5678);
    @(negedge clk);
    rd(8'h04, v); chk("R10 two edges", v, 32'hCAFE_F00D);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule